// File: doc/BRIEF.md
# Bidirectional Parallel Printer Port Controller

This block runs an 8-bit printer-style parallel port from the host clock, in either direction. When sending, it drives a byte from a one-byte holding register onto the data pins. It waits a programmable setup time, pulses the active-low strobe for a programmable width, and then finishes the byte once the peripheral answers with a clean acknowledge pulse. A busy level from the peripheral pauses the setup phase, so the strobe waits until the peripheral is ready.

When receiving, the block watches the peripheral's strobe. It raises busy as soon as the synchronised strobe is seen. Once the strobe has lasted long enough to count, it latches the byte and returns an acknowledge pulse of the programmed width. A single direction bit sets all four transceiver-direction pins together.

All peripheral inputs pass through a two-flop synchroniser. Strobe, acknowledge and busy are then filtered so that a pulse shorter than three host clocks is ignored. Software uses a plain synchronous register port, which accepts every access without back-pressure; read data appears one clock after the read strobe. A completion flag drives a level interrupt request.

Top module: `ppc_ctrl`

## Requirements
- R1: Control register (address 1) bit 0 selects direction. At 0 (send), `dir_data_o` = `dir_stb_o` = 1 and `dir_busy_o` = `dir_ack_o` = 0. At 1 (receive), all four are inverted. The pins change on the clock edge that takes the write.
- R2: A write to the data register (address 0) in send direction with no byte in flight latches the byte on `pp_data_o` at once. `pp_stb_n_o` goes low setup+1 clock edges after the write edge. The setup field is bits [1:0] of the timing register (address 2).
- R3: The send strobe stays low for exactly 3+width clocks. The width field is timing-register bits [3:2]. The strobe is never shorter than 3 clocks.
- R4: After the strobe, the block waits the number of clocks in the hold field (timing-register bits [5:4]). It then waits for an acknowledge pulse that is recognised. The byte then completes: status bit 0 (done) sets and status bit 2 (send in progress) clears.
- R5: An acknowledge, busy or strobe input is recognised only after it has been active for 3 consecutive synchronised clocks. A 2-clock acknowledge pulse leaves the send in progress.
- R6: While the filtered peripheral busy is high, the setup phase holds and the strobe does not assert. After busy is released, the strobe falls 4 edges later when the setup field is 0.
- R7: In receive direction, `pp_busy_o` rises 3 clock edges after `pp_stb_n_i` falls. This is the first edge after the synchroniser output shows the strobe.
- R8: A receive strobe held low for at least 3 clocks drives `pp_ack_n_o` low starting 6 edges after the strobe fell, for 3+width clocks. The captured byte is read back from address 0, and done sets when the acknowledge ends.
- R9: A receive strobe shorter than 3 clocks produces no acknowledge. Busy drops again, the received byte is unchanged, and done stays clear.
- R10: `irq_o` follows the done flag. Reading the status register (address 3) returns done and then clears it.
- R11: A data write while a send is in flight is ignored: `pp_data_o` keeps its byte and status bit 1 (overrun) sets. Overrun stays set across reads and clears when status is written with bit 1 = 1.
- R12: Control bits 1, 2 and 3 drive `pp_init_o`, `pp_selin_o` and `pp_afeed_o`. Status bits 5, 6 and 7 report the synchronised fault (active low at the pin), select and paper-end inputs. Status bit 4 is the filtered peripheral busy and bit 3 is receive in progress.
- R13: A read returns the addressed register on `reg_rdata_o` one clock edge after `reg_rd_i` is sampled. The control register reads back its written low 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, registered |
| irq_o | output | 1 | Level interrupt request (done flag) |
| pp_data_o | output | DATA_W | Outbound data byte |
| pp_data_i | input | DATA_W | Inbound data byte |
| pp_stb_n_o | output | 1 | Outbound strobe, active low |
| pp_stb_n_i | input | 1 | Inbound strobe, active low |
| pp_ack_n_o | output | 1 | Acknowledge to peripheral, active low |
| pp_ack_n_i | input | 1 | Acknowledge from peripheral, active low |
| pp_busy_o | output | 1 | Busy to peripheral |
| pp_busy_i | input | 1 | Busy from peripheral |
| pp_fault_n_i | input | 1 | Peripheral fault, active low |
| pp_select_i | input | 1 | Peripheral selected |
| pp_paper_i | input | 1 | Paper end |
| pp_init_o | output | 1 | Initialise control line |
| pp_selin_o | output | 1 | Select-in control line |
| pp_afeed_o | output | 1 | Auto-feed control line |
| dir_data_o | output | 1 | Data transceiver direction |
| dir_stb_o | output | 1 | Strobe transceiver direction |
| dir_busy_o | output | 1 | Busy transceiver direction |
| dir_ack_o | output | 1 | Acknowledge transceiver direction |

## Verification
Every result has a fixed delay, and each check counts the clock edges to that point.

- **Send:** the strobe falls setup+1 edges after the data write and stays low 3+width clocks. The bench counts edges from the write until the strobe falls, then counts the strobe samples.
- **Inputs:** an input change reaches the filter 2 edges after the pin moves. A recognised pulse takes effect 3 edges after that.
- **Receive:** busy is due at edge 3 and the acknowledge at edge 6, counted from the strobe falling. The bench logs the first edge at which each appears.
- **Registers:** read data is sampled once, one edge after the read.
- **Ignored stimulus:** glitch and overrun cases wait well beyond the longest latency before reading status or the data pins.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int FIELD_W = 2;
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_TIME = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  typedef struct packed {
    logic afeed;
    logic selin;
    logic init;
    logic dir;
  } ctrl_t;

  typedef struct packed {
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] width;
    logic [FIELD_W-1:0] setup;
  } timing_t;

  typedef enum logic [2:0] {TX_IDLE, TX_SETUP, TX_STROBE, TX_HOLD, TX_WAIT} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_SEEN, RX_ACK} rx_state_e;
endpackage

// File: rtl/ppc_sync.sv
module ppc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[i] <= RST_VAL;
        else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ppc_pulse_filter.sv
module ppc_pulse_filter #(
  parameter int MIN_PULSE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic level_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] FULL = CW'(MIN_PULSE);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic level_q;

  always_comb begin
    if (!sig_i)             cnt_d = '0;
    else if (cnt_q == FULL) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      level_q <= (cnt_d == FULL);
    end
  end

  assign level_o = level_q;

  // R5
  short_pulse_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_q) |-> ($past(sig_i) && $past(sig_i, 2) && $past(sig_i, 3)));
endmodule

// File: rtl/ppc_tx_engine.sv
module ppc_tx_engine import ppc_pkg::*; #(
  parameter int MIN_PULSE = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               start_i,
  input  logic [FIELD_W-1:0] setup_i,
  input  logic [FIELD_W-1:0] width_i,
  input  logic [FIELD_W-1:0] hold_i,
  input  logic               busy_i,
  input  logic               ack_rise_i,
  output logic               strobe_o,
  output logic               active_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(MIN_PULSE + (1 << FIELD_W));
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] BASE = CNT_W'(MIN_PULSE - 1);

  tx_state_e          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FIELD_W-1:0] width_q, hold_q;
  logic               done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      width_q <= '0;
      hold_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!enable_i) begin
        state_q <= TX_IDLE;
      end else begin
        unique case (state_q)
          TX_IDLE: if (start_i) begin
            state_q <= TX_SETUP;
            cnt_q   <= CNT_W'(setup_i);
            width_q <= width_i;
            hold_q  <= hold_i;
          end
          TX_SETUP: if (!busy_i) begin
            if (cnt_q == '0) begin
              state_q <= TX_STROBE;
              cnt_q   <= BASE + CNT_W'(width_q);
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
          TX_STROBE: begin
            if (cnt_q == '0) begin
              if (hold_q == '0) begin
                state_q <= TX_WAIT;
              end else begin
                state_q <= TX_HOLD;
                cnt_q   <= CNT_W'(hold_q) - ONE;
              end
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
          TX_HOLD: begin
            if (cnt_q == '0) state_q <= TX_WAIT;
            else             cnt_q   <= cnt_q - ONE;
          end
          TX_WAIT: if (ack_rise_i) begin
            state_q <= TX_IDLE;
            done_q  <= 1'b1;
          end
          default: state_q <= TX_IDLE;
        endcase
      end
    end
  end

  assign strobe_o = (state_q == TX_STROBE);
  assign active_o = (state_q != TX_IDLE);
  assign done_o   = done_q;

  // R3
  strobe_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> ($past(strobe_o, 2) && $past(strobe_o, 3)));

  // R6
  busy_holds_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_SETUP && busy_i) |=> !strobe_o);
endmodule

// File: rtl/ppc_rx_engine.sv
module ppc_rx_engine import ppc_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int MIN_PULSE = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               stb_seen_i,
  input  logic               stb_rise_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [FIELD_W-1:0] width_i,
  output logic               busy_o,
  output logic               ack_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               done_o
);
  localparam int CNT_W = $clog2(MIN_PULSE + (1 << FIELD_W));
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] BASE = CNT_W'(MIN_PULSE - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] cap_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      cap_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!enable_i) begin
        state_q <= RX_IDLE;
      end else begin
        unique case (state_q)
          RX_IDLE: if (stb_seen_i) state_q <= RX_SEEN;
          RX_SEEN: begin
            if (stb_rise_i) begin
              state_q <= RX_ACK;
              cap_q   <= data_i;
              cnt_q   <= BASE + CNT_W'(width_i);
            end else if (!stb_seen_i) begin
              state_q <= RX_IDLE;
            end
          end
          RX_ACK: begin
            if (cnt_q == '0) begin
              state_q <= RX_IDLE;
              done_q  <= 1'b1;
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != RX_IDLE);
  assign ack_o  = (state_q == RX_ACK);
  assign data_o = cap_q;
  assign done_o = done_q;

  // R7
  busy_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stb_seen_i));

  // R8
  ack_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> ($past(ack_o, 2) && $past(ack_o, 3)));
endmodule

// File: rtl/ppc_ctrl.sv
module ppc_ctrl import ppc_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int MIN_PULSE = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] pp_data_o,
  input  logic [DATA_W-1:0] pp_data_i,
  output logic              pp_stb_n_o,
  input  logic              pp_stb_n_i,
  output logic              pp_ack_n_o,
  input  logic              pp_ack_n_i,
  output logic              pp_busy_o,
  input  logic              pp_busy_i,
  input  logic              pp_fault_n_i,
  input  logic              pp_select_i,
  input  logic              pp_paper_i,
  output logic              pp_init_o,
  output logic              pp_selin_o,
  output logic              pp_afeed_o,
  output logic              dir_data_o,
  output logic              dir_stb_o,
  output logic              dir_busy_o,
  output logic              dir_ack_o
);
  localparam int NCTL = 6;
  localparam int NFLT = 3;
  localparam int CTRL_W = $bits(ctrl_t);
  localparam int TIME_W = $bits(timing_t);
  localparam logic [NCTL-1:0] CTL_RST = 6'b001011;

  ctrl_t             ctrl_q;
  timing_t           timing_q;
  logic [DATA_W-1:0] tx_hold_q;
  logic              done_q, ovr_q;
  logic [DATA_W-1:0] rdata_q;

  logic [NCTL-1:0]   ctl_s;
  logic [DATA_W-1:0] data_s;
  logic [NFLT-1:0]   act, lvl;
  logic [1:0]        lvl_q, rise;

  logic tx_strobe, tx_active, tx_done;
  logic rx_busy, rx_ack, rx_done;
  logic [DATA_W-1:0] rx_data;
  logic wr_data, start, done_set;
  logic [7:0] status;

  ppc_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n),
    .d_i({pp_paper_i, pp_select_i, pp_fault_n_i, pp_busy_i, pp_ack_n_i, pp_stb_n_i}),
    .q_o(ctl_s));

  ppc_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d_i(pp_data_i), .q_o(data_s));

  assign act = {ctl_s[2], ~ctl_s[1], ~ctl_s[0]};

  for (genvar i = 0; i < NFLT; i++) begin : g_flt
    ppc_pulse_filter #(.MIN_PULSE(MIN_PULSE)) u_flt (
      .clk(clk), .rst_n(rst_n), .sig_i(act[i]), .level_o(lvl[i]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl[1:0];

  assign rise = lvl[1:0] & ~lvl_q;

  assign wr_data = reg_wr_i && (reg_addr_i == A_DATA);
  assign start   = wr_data && !ctrl_q.dir && !tx_active;

  ppc_tx_engine #(.MIN_PULSE(MIN_PULSE)) u_tx (
    .clk(clk), .rst_n(rst_n), .enable_i(!ctrl_q.dir), .start_i(start),
    .setup_i(timing_q.setup), .width_i(timing_q.width), .hold_i(timing_q.hold),
    .busy_i(lvl[2]), .ack_rise_i(rise[1]),
    .strobe_o(tx_strobe), .active_o(tx_active), .done_o(tx_done));

  ppc_rx_engine #(.DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable_i(ctrl_q.dir), .stb_seen_i(act[0]),
    .stb_rise_i(rise[0]), .data_i(data_s), .width_i(timing_q.width),
    .busy_o(rx_busy), .ack_o(rx_ack), .data_o(rx_data), .done_o(rx_done));

  assign done_set = tx_done || rx_done;
  assign status = {ctl_s[5], ctl_s[4], ~ctl_s[3], lvl[2], rx_busy, tx_active, ovr_q, done_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      timing_q  <= '0;
      tx_hold_q <= '0;
      done_q    <= 1'b0;
      ovr_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (reg_wr_i) begin
        unique case (reg_addr_i)
          A_DATA: begin
            if (!ctrl_q.dir && tx_active) ovr_q <= 1'b1;
            else                          tx_hold_q <= reg_wdata_i;
          end
          A_CTRL: ctrl_q   <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
          A_TIME: timing_q <= timing_t'(reg_wdata_i[TIME_W-1:0]);
          A_STAT: if (reg_wdata_i[1]) ovr_q <= 1'b0;
          default: ;
        endcase
      end
      if (done_set)                                done_q <= 1'b1;
      else if (reg_rd_i && reg_addr_i == A_STAT)   done_q <= 1'b0;
      if (reg_rd_i) begin
        unique case (reg_addr_i)
          A_DATA:  rdata_q <= rx_data;
          A_CTRL:  rdata_q <= DATA_W'(ctrl_q);
          A_TIME:  rdata_q <= DATA_W'(timing_q);
          default: rdata_q <= DATA_W'(status);
        endcase
      end
    end
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = done_q;
  assign pp_data_o   = tx_hold_q;
  assign pp_stb_n_o  = ~tx_strobe;
  assign pp_ack_n_o  = ~rx_ack;
  assign pp_busy_o   = rx_busy;
  assign pp_init_o   = ctrl_q.init;
  assign pp_selin_o  = ctrl_q.selin;
  assign pp_afeed_o  = ctrl_q.afeed;
  assign dir_data_o  = ~ctrl_q.dir;
  assign dir_stb_o   = ~ctrl_q.dir;
  assign dir_busy_o  = ctrl_q.dir;
  assign dir_ack_o   = ctrl_q.dir;

  // R1
  dir_pairs_follow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_CTRL) |=>
      (dir_busy_o == $past(reg_wdata_i[0])) && (dir_stb_o != $past(reg_wdata_i[0])));

  // R10
  irq_clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == A_STAT && !done_set) |=> !irq_o);

  // R11
  overrun_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !ctrl_q.dir && tx_active) |=> ($stable(pp_data_o) && ovr_q));
endmodule

// File: tb/ppc_ctrl_tb.sv
`timescale 1ns/1ps
module ppc_ctrl_tb;
  localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_TIME = 2'd2, A_STAT = 2'd3;
  localparam int NVEC = 5;
  // {dir, byte, setup, width, hold}
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0, 8'hA5, 2'd0, 2'd0, 2'd3},
    {1'b0, 8'h3C, 2'd3, 2'd2, 2'd0},
    {1'b1, 8'h5A, 2'd0, 2'd1, 2'd0},
    {1'b1, 8'hC3, 2'd0, 2'd3, 2'd0},
    {1'b0, 8'h81, 2'd1, 2'd3, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq;
  logic [7:0] pp_data_o, pp_data_i = '0;
  logic pp_stb_n_o, pp_stb_n_i = 1'b1, pp_ack_n_o, pp_ack_n_i = 1'b1;
  logic pp_busy_o, pp_busy_i = 1'b0;
  logic pp_fault_n_i = 1'b1, pp_select_i = 1'b0, pp_paper_i = 1'b0;
  logic pp_init_o, pp_selin_o, pp_afeed_o;
  logic dir_data_o, dir_stb_o, dir_busy_o, dir_ack_o;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ppc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .pp_data_o(pp_data_o), .pp_data_i(pp_data_i),
    .pp_stb_n_o(pp_stb_n_o), .pp_stb_n_i(pp_stb_n_i),
    .pp_ack_n_o(pp_ack_n_o), .pp_ack_n_i(pp_ack_n_i),
    .pp_busy_o(pp_busy_o), .pp_busy_i(pp_busy_i),
    .pp_fault_n_i(pp_fault_n_i), .pp_select_i(pp_select_i), .pp_paper_i(pp_paper_i),
    .pp_init_o(pp_init_o), .pp_selin_o(pp_selin_o), .pp_afeed_o(pp_afeed_o),
    .dir_data_o(dir_data_o), .dir_stb_o(dir_stb_o),
    .dir_busy_o(dir_busy_o), .dir_ack_o(dir_ack_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse_ack(input int n);
    pp_ack_n_i = 1'b0;
    repeat (n) @(posedge clk);
    #1 pp_ack_n_i = 1'b1;
  endtask

  task automatic wait_strobe_done();
    int g = 0;
    while (pp_stb_n_o && g < 40) begin @(posedge clk); #1; g++; end
    while (!pp_stb_n_o && g < 80) begin @(posedge clk); #1; g++; end
  endtask

  task automatic tx_run(input logic [7:0] b, input int s, input int w, input int h);
    int n = 0, wid = 0;
    logic [7:0] st;
    wr(A_DATA, b);
    while (pp_stb_n_o && n < 40) begin @(posedge clk); #1; n++; end
    chk("R2 strobe start edge", n, s + 1);
    chk("R2 data on pins", pp_data_o, b);
    while (!pp_stb_n_o && wid < 40) begin wid++; @(posedge clk); #1; end
    chk("R3 strobe width", wid, 3 + w);
    repeat (h + 1) @(posedge clk);
    #1 pulse_ack(3);
    repeat (8) @(posedge clk);
    #1 chk("R10 irq raised", irq, 1);
    rd(A_STAT, st);
    chk("R4 done set", st[0], 1);
    chk("R4 send finished", st[2], 0);
  endtask

  task automatic rx_run(input logic [7:0] b, input int w);
    int busy_at = 0, ack_at = 0, ackw = 0;
    logic [7:0] d;
    pp_data_i = b;
    pp_stb_n_i = 1'b0;
    for (int e = 1; e <= 20; e++) begin
      @(posedge clk); #1;
      if (e == 3) pp_stb_n_i = 1'b1;
      if (pp_busy_o && busy_at == 0) busy_at = e;
      if (!pp_ack_n_o) begin
        if (ack_at == 0) ack_at = e;
        ackw++;
      end
    end
    chk("R7 busy edge", busy_at, 3);
    chk("R8 ack edge", ack_at, 6);
    chk("R8 ack width", ackw, 3 + w);
    chk("R8 busy released", pp_busy_o, 0);
    rd(A_DATA, d);
    chk("R8 captured byte", d, b);
    rd(A_STAT, d);
    chk("R8 done set", d[0], 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // reset state
    chk("R1 reset dir_data", dir_data_o, 1);
    chk("R1 reset dir_stb", dir_stb_o, 1);
    chk("R1 reset dir_busy", dir_busy_o, 0);
    chk("R1 reset dir_ack", dir_ack_o, 0);
    chk("R2 reset strobe idle", pp_stb_n_o, 1);
    chk("R8 reset ack idle", pp_ack_n_o, 1);
    chk("R7 reset busy idle", pp_busy_o, 0);
    chk("R10 reset irq", irq, 0);
    chk("R12 reset init", pp_init_o, 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      wr(A_TIME, {2'b00, VEC[i][1:0], VEC[i][3:2], VEC[i][5:4]});
      wr(A_CTRL, {7'd0, VEC[i][14]});
      if (VEC[i][14]) begin
        chk("R1 inbound dir_data", dir_data_o, 0);
        chk("R1 inbound dir_ack", dir_ack_o, 1);
        rx_run(VEC[i][13:6], int'(VEC[i][3:2]));
      end else begin
        chk("R1 outbound dir_stb", dir_stb_o, 1);
        chk("R1 outbound dir_busy", dir_busy_o, 0);
        tx_run(VEC[i][13:6], int'(VEC[i][5:4]), int'(VEC[i][3:2]), int'(VEC[i][1:0]));
      end
    end

    // R12 / R13 control pins and status inputs
    wr(A_CTRL, 8'h0E);
    chk("R12 init pin", pp_init_o, 1);
    chk("R12 selin pin", pp_selin_o, 1);
    chk("R12 afeed pin", pp_afeed_o, 1);
    pp_fault_n_i = 1'b0; pp_select_i = 1'b1; pp_paper_i = 1'b1;
    repeat (4) @(posedge clk);
    #1 rd(A_STAT, st);
    chk("R12 status inputs", st[7:5], 3'b111);
    rd(A_CTRL, st);
    chk("R13 ctrl readback", st, 8'h0E);
    pp_fault_n_i = 1'b1; pp_select_i = 1'b0; pp_paper_i = 1'b0;
    wr(A_CTRL, 8'h00);
    wr(A_TIME, 8'h00);

    // R5 short acknowledge ignored
    wr(A_DATA, 8'h66);
    wait_strobe_done();
    repeat (2) @(posedge clk);
    #1 pulse_ack(2);
    repeat (10) @(posedge clk);
    #1 rd(A_STAT, st);
    chk("R5 send still in progress", st[2], 1);
    chk("R5 no done", st[0], 0);
    pulse_ack(3);
    repeat (8) @(posedge clk);
    #1 chk("R10 irq high", irq, 1);
    rd(A_STAT, st);
    chk("R10 done read", st[0], 1);
    chk("R10 irq cleared", irq, 0);
    rd(A_STAT, st);
    chk("R10 done cleared", st[0], 0);

    // R6 busy holds off the strobe
    pp_busy_i = 1'b1;
    repeat (6) @(posedge clk);
    #1 wr(A_DATA, 8'h77);
    repeat (10) @(posedge clk);
    #1 chk("R6 strobe held", pp_stb_n_o, 1);
    rd(A_STAT, st);
    chk("R6 busy status", st[4], 1);
    pp_busy_i = 1'b0;
    n = 0;
    while (pp_stb_n_o && n < 20) begin @(posedge clk); #1; n++; end
    chk("R6 strobe after release", n, 4);
    wait_strobe_done();
    repeat (2) @(posedge clk);
    #1 pulse_ack(3);
    repeat (8) @(posedge clk);
    #1 rd(A_STAT, st);

    // R11 overrun
    wr(A_DATA, 8'h11);
    repeat (2) @(posedge clk);
    #1 wr(A_DATA, 8'h22);
    chk("R11 byte kept", pp_data_o, 8'h11);
    rd(A_STAT, st);
    chk("R11 overrun set", st[1], 1);
    rd(A_STAT, st);
    chk("R11 overrun sticky", st[1], 1);
    wait_strobe_done();
    repeat (2) @(posedge clk);
    #1 pulse_ack(3);
    repeat (8) @(posedge clk);
    #1 chk("R11 byte still kept", pp_data_o, 8'h11);
    wr(A_STAT, 8'h02);
    rd(A_STAT, st);
    chk("R11 overrun cleared", st[1], 0);

    // R9 short inbound strobe ignored
    wr(A_CTRL, 8'h01);
    pp_data_i = 8'hEE;
    pp_stb_n_i = 1'b0;
    n = 0;
    for (int e = 1; e <= 15; e++) begin
      @(posedge clk); #1;
      if (e == 2) pp_stb_n_i = 1'b1;
      if (!pp_ack_n_o) n++;
    end
    chk("R9 no ack", n, 0);
    chk("R9 busy released", pp_busy_o, 0);
    rd(A_DATA, st);
    chk("R9 byte unchanged", st, 8'hC3);
    rd(A_STAT, st);
    chk("R9 no done", st[0], 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule